// File: doc/BRIEF.md
# Programmable Address Sequencer with Hardware Loops

This block produces the address stream for one 64-word by 16-bit local data memory. A host first writes a short program into a private 64-word by 32-bit instruction store through a load port, then pulses a start strobe that carries the entry point. The sequencer steps through the program one instruction per cycle. It emits an address whenever it reaches an address-generation instruction for which the consumer is asking.

An address pointer and a modulo window are held in registers. Each generation instruction selects post-increment, pre-increment, modulo-wrapped or bit-reversed output. A loop unit shared by the program provides four nested hardware loops, so loop bodies repeat without any branch instructions or bubbles. When the consumer is not asking, the sequencer holds on the pending generation instruction and does not fetch further. After a halt instruction it sits idle until the next start strobe wakes it.

Top module: `addrgen_seq`

## Requirements
- R1: While reset is asserted, and after it is released with no start, `addr_vld` is 0 and the sequencer is idle.
- R2: A write with `ld_we` high stores `ld_data` at word `ld_addr` of the 64 x 32 instruction store. A cycle with `start` high makes the sequencer run from word `start_pc` in the next cycle.
- R3: An instruction with opcode bits [31:28] = 4 (generate) and mode bits [25:24] = 0 (post-increment) outputs the pointer. The pointer then advances by the step in bits [21:16], modulo 64.
- R4: In mode 1 (pre-increment), the pointer advances by the step first, and the new pointer is output.
- R5: In mode 2 (modulo), the pointer is output. The next pointer is pointer+step, and the window length is subtracted if that sum reaches base+length.
- R6: In mode 3 (bit-reverse), the output is the pointer with its low N bits in reversed order, where N is bits [14:12] (1..6). The pointer then advances by the step.
- R7: Each accepted generate instruction produces `addr_vld` high, with the address, in the following cycle. While a generate instruction is pending and `addr_req` is low, no address is emitted and the program does not advance.
- R8: Opcode 5 (halt) makes the sequencer idle. Further `addr_req` produces no address until the next start.
- R9: Opcode 3 (loop) arms level bits [27:26]. The body is the next (bits[10:8]+1) instructions, and it executes (bits[7:0]+1) times. Consecutive generate instructions in a repeating body produce addresses in consecutive cycles.
- R10: Higher level numbers nest inside lower ones. When an inner loop ends on the same word as an outer one, the outer loop is checked in that same cycle, with no extra cycle.
- R11: Opcode 1 loads the pointer from bits [5:0]. Opcode 2 loads the modulo base from bits [5:0] and the length from bits [11:6]. Neither emits an address.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| ld_we | input | 1 | Instruction store write enable |
| ld_addr | input | 6 | Instruction store write word |
| ld_data | input | 32 | Instruction word to store |
| start | input | 1 | Start/wake strobe |
| start_pc | input | 6 | Entry word for the program |
| addr_req | input | 1 | Consumer asks for an address |
| addr | output | 6 | Generated data memory address |
| addr_vld | output | 1 | Address valid |

## Verification
A corrupted pointer or modulo window shows up in the very next emitted address, one cycle after the generate instruction is accepted. A wrong loop counter or end pointer changes how many addresses appear before the halt, and it changes the spacing between them. For that reason, the number of addresses and the span between the first and last are compared against exact values. A stall or idle fault shows up as an address emitted in a cycle where the consumer did not ask, or after a halt.

// File: rtl/addrgen_pkg.sv
`timescale 1ns/1ps
package addrgen_pkg;
  localparam logic [3:0] OP_NOP  = 4'd0;
  localparam logic [3:0] OP_SETP = 4'd1;
  localparam logic [3:0] OP_SETM = 4'd2;
  localparam logic [3:0] OP_LOOP = 4'd3;
  localparam logic [3:0] OP_GEN  = 4'd4;
  localparam logic [3:0] OP_HALT = 4'd5;

  localparam logic [1:0] AM_POST = 2'd0;
  localparam logic [1:0] AM_PRE  = 2'd1;
  localparam logic [1:0] AM_MOD  = 2'd2;
  localparam logic [1:0] AM_BREV = 2'd3;
endpackage

// File: rtl/addrgen_imem.sv
`timescale 1ns/1ps
module addrgen_imem #(
  parameter int DEPTH = 64,
  parameter int W     = 32,
  localparam int AW   = $clog2(DEPTH)
) (
  input  logic          clk,
  input  logic          we,
  input  logic [AW-1:0] waddr,
  input  logic [W-1:0]  wdata,
  input  logic [AW-1:0] raddr,
  output logic [W-1:0]  rdata
);
  logic [W-1:0] mem_q [DEPTH];

  always_ff @(posedge clk) begin
    if (we) mem_q[waddr] <= wdata;
  end

  assign rdata = mem_q[raddr];
endmodule

// File: rtl/addrgen_loop_unit.sv
`timescale 1ns/1ps
module addrgen_loop_unit #(
  parameter int LEVELS = 4,
  parameter int PW     = 6,
  parameter int CW     = 8,
  parameter int BW     = 3,
  localparam int LW    = $clog2(LEVELS)
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic [PW-1:0] pc,
  input  logic          advance,
  input  logic          setup,
  input  logic [LW-1:0] setup_lvl,
  input  logic [BW-1:0] setup_body,
  input  logic [CW-1:0] setup_cnt,
  output logic [PW-1:0] next_pc,
  output logic          jump
);
  logic [LEVELS-1:0] act_q, act_n;
  logic [PW-1:0]     st_q  [LEVELS];
  logic [PW-1:0]     st_n  [LEVELS];
  logic [PW-1:0]     end_q [LEVELS];
  logic [PW-1:0]     end_n [LEVELS];
  logic [CW-1:0]     cnt_q [LEVELS];
  logic [CW-1:0]     cnt_n [LEVELS];

  // innermost level first; an exhausted level falls through to the next outer one
  always_comb begin
    logic found;
    found   = 1'b0;
    next_pc = pc + PW'(1);
    jump    = 1'b0;
    act_n   = act_q;
    st_n    = st_q;
    end_n   = end_q;
    cnt_n   = cnt_q;
    for (int l = LEVELS-1; l >= 0; l--) begin
      if (advance && !found && act_q[l] && (pc == end_q[l])) begin
        if (cnt_q[l] != '0) begin
          next_pc  = st_q[l];
          cnt_n[l] = cnt_q[l] - CW'(1);
          jump     = 1'b1;
          found    = 1'b1;
        end else begin
          act_n[l] = 1'b0;
        end
      end
    end
    if (setup) begin
      act_n[setup_lvl] = 1'b1;
      st_n[setup_lvl]  = pc + PW'(1);
      end_n[setup_lvl] = pc + PW'(1) + PW'(setup_body);
      cnt_n[setup_lvl] = setup_cnt;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      act_q <= '0;
      for (int l = 0; l < LEVELS; l++) begin
        st_q[l]  <= '0;
        end_q[l] <= '0;
        cnt_q[l] <= '0;
      end
    end else begin
      act_q <= act_n;
      st_q  <= st_n;
      end_q <= end_n;
      cnt_q <= cnt_n;
    end
  end
endmodule

// File: rtl/addrgen_addr_dp.sv
`timescale 1ns/1ps
module addrgen_addr_dp #(
  parameter int AW   = 6,
  localparam int NBW = $clog2(AW + 1)
) (
  input  logic           clk,
  input  logic           rst_n,
  input  logic           gen_en,
  input  logic [1:0]     mode,
  input  logic [AW-1:0]  step,
  input  logic [NBW-1:0] nbits,
  input  logic           setp_en,
  input  logic [AW-1:0]  setp_val,
  input  logic           setm_en,
  input  logic [AW-1:0]  base_val,
  input  logic [AW-1:0]  len_val,
  output logic [AW-1:0]  addr,
  output logic           addr_vld
);
  import addrgen_pkg::*;

  logic [AW-1:0] ptr_q, ptr_n, base_q, len_q, addr_q, out_n;
  logic          vld_q;
  logic [AW:0]   wide, lim, wrap;

  function automatic logic [AW-1:0] rev_low(input logic [AW-1:0] p, input logic [NBW-1:0] n);
    int k;
    k = (int'(n) > AW) ? AW : int'(n);
    rev_low = p;
    for (int i = 0; i < AW; i++) begin
      if (i < k) rev_low[i] = p[k-1-i];
    end
  endfunction

  always_comb begin
    wide = {1'b0, ptr_q} + {1'b0, step};
    lim  = {1'b0, base_q} + {1'b0, len_q};
    wrap = wide - {1'b0, len_q};
    ptr_n = wide[AW-1:0];
    out_n = ptr_q;
    case (mode)
      AM_PRE:  out_n = wide[AW-1:0];
      AM_MOD:  if (wide >= lim) ptr_n = wrap[AW-1:0];
      AM_BREV: out_n = rev_low(ptr_q, nbits);
      default: out_n = ptr_q;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ptr_q  <= '0;
      base_q <= '0;
      len_q  <= '0;
      addr_q <= '0;
      vld_q  <= 1'b0;
    end else begin
      vld_q <= gen_en;
      if (gen_en) begin
        addr_q <= out_n;
        ptr_q  <= ptr_n;
      end else if (setp_en) begin
        ptr_q <= setp_val;
      end
      if (setm_en) begin
        base_q <= base_val;
        len_q  <= len_val;
      end
    end
  end

  assign addr     = addr_q;
  assign addr_vld = vld_q;
endmodule

// File: rtl/addrgen_seq.sv
`timescale 1ns/1ps
module addrgen_seq #(
  parameter int IW     = 32,
  parameter int DEPTH  = 64,
  parameter int AW     = 6,
  parameter int LEVELS = 4,
  parameter int CW     = 8,
  parameter int BW     = 3,
  localparam int PCW   = $clog2(DEPTH),
  localparam int LW    = $clog2(LEVELS),
  localparam int NBW   = $clog2(AW + 1)
) (
  input  logic           clk,
  input  logic           rst_n,
  input  logic           ld_we,
  input  logic [PCW-1:0] ld_addr,
  input  logic [IW-1:0]  ld_data,
  input  logic           start,
  input  logic [PCW-1:0] start_pc,
  input  logic           addr_req,
  output logic [AW-1:0]  addr,
  output logic           addr_vld
);
  import addrgen_pkg::*;

  logic           run_q, run_n;
  logic [PCW-1:0] pc_q, pc_n, lp_next;
  logic [IW-1:0]  instr;
  logic [3:0]     op;
  logic           is_gen, stall, advance, lp_adv, lp_jump;
  logic           gen_en, setp_en, setm_en, loop_en;
  logic           unused_instr;

  addrgen_imem #(.DEPTH(DEPTH), .W(IW)) u_imem (
    .clk(clk), .we(ld_we), .waddr(ld_addr), .wdata(ld_data),
    .raddr(pc_q), .rdata(instr)
  );

  assign op           = instr[31:28];
  assign unused_instr = ^instr;
  assign is_gen       = run_q && (op == OP_GEN);
  assign stall        = is_gen && !addr_req;
  assign advance      = run_q && !stall && !start;
  assign lp_adv       = advance && (op != OP_HALT);
  assign gen_en       = advance && (op == OP_GEN);
  assign setp_en      = advance && (op == OP_SETP);
  assign setm_en      = advance && (op == OP_SETM);
  assign loop_en      = advance && (op == OP_LOOP);

  addrgen_loop_unit #(.LEVELS(LEVELS), .PW(PCW), .CW(CW), .BW(BW)) u_loop (
    .clk(clk), .rst_n(rst_n), .pc(pc_q), .advance(lp_adv),
    .setup(loop_en), .setup_lvl(instr[26 +: LW]),
    .setup_body(instr[8 +: BW]), .setup_cnt(instr[CW-1:0]),
    .next_pc(lp_next), .jump(lp_jump)
  );

  addrgen_addr_dp #(.AW(AW)) u_dp (
    .clk(clk), .rst_n(rst_n), .gen_en(gen_en), .mode(instr[25:24]),
    .step(instr[16 +: AW]), .nbits(instr[12 +: NBW]),
    .setp_en(setp_en), .setp_val(instr[AW-1:0]),
    .setm_en(setm_en), .base_val(instr[AW-1:0]), .len_val(instr[AW +: AW]),
    .addr(addr), .addr_vld(addr_vld)
  );

  always_comb begin
    run_n = run_q;
    pc_n  = pc_q;
    if (start) begin
      run_n = 1'b1;
      pc_n  = start_pc;
    end else if (advance) begin
      if (op == OP_HALT) run_n = 1'b0;
      else               pc_n  = lp_next;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      run_q <= 1'b0;
      pc_q  <= '0;
    end else begin
      run_q <= run_n;
      pc_q  <= pc_n;
    end
  end
endmodule

// File: rtl/addrgen_chk.sv
`timescale 1ns/1ps
module addrgen_chk #(
  parameter int PCW = 6
) (
  input logic           clk,
  input logic           rst_n,
  input logic           start,
  input logic [PCW-1:0] start_pc,
  input logic           addr_req,
  input logic           addr_vld,
  input logic           run,
  input logic [PCW-1:0] pc,
  input logic [3:0]     op,
  input logic           loop_jump,
  input logic [PCW-1:0] loop_target
);
  a_r2_start_loads: assert property (@(posedge clk) disable iff (!rst_n)
    start |=> (run && pc == $past(start_pc)));

  a_r7_vld_needs_req: assert property (@(posedge clk) disable iff (!rst_n)
    addr_vld |-> $past(addr_req));

  a_r7_stall_holds: assert property (@(posedge clk) disable iff (!rst_n)
    (run && op == 4'd4 && !addr_req && !start) |=> ($stable(pc) && !addr_vld));

  a_r8_idle_quiet: assert property (@(posedge clk) disable iff (!rst_n)
    (!run && !start) |=> !addr_vld);

  a_r9_jump_target: assert property (@(posedge clk) disable iff (!rst_n)
    (loop_jump && !start) |=> (pc == $past(loop_target)));
endmodule

bind addrgen_seq addrgen_chk #(.PCW(PCW)) u_chk (
  .clk(clk), .rst_n(rst_n), .start(start), .start_pc(start_pc),
  .addr_req(addr_req), .addr_vld(addr_vld), .run(run_q), .pc(pc_q),
  .op(op), .loop_jump(lp_jump), .loop_target(lp_next)
);

// File: tb/tb_addrgen_seq.sv
`timescale 1ns/1ps
module tb_addrgen_seq;
  logic        clk = 1'b0;
  logic        rst_n, ld_we, start, addr_req;
  logic [5:0]  ld_addr, start_pc;
  logic [31:0] ld_data;
  logic [5:0]  addr;
  logic        addr_vld;
  int checks = 0, errors = 0, cyc = 0;

  addrgen_seq dut (
    .clk(clk), .rst_n(rst_n), .ld_we(ld_we), .ld_addr(ld_addr), .ld_data(ld_data),
    .start(start), .start_pc(start_pc), .addr_req(addr_req),
    .addr(addr), .addr_vld(addr_vld)
  );

  always #4 clk = ~clk;
  always @(posedge clk) cyc++;

  // three programs: words 0..3, 4..8, 9..13
  localparam logic [31:0] PROG [14] = '{
    32'h1000000A, 32'h40010000, 32'h41020000, 32'h50000000,
    32'h20000154, 32'h10000016, 32'h30000005, 32'h42020000, 32'h50000000,
    32'h10000000, 32'h30000101, 32'h3C000002, 32'h43013000, 32'h50000000
  };
  localparam logic [5:0] EXP [14] = '{
    6'd10, 6'd13,
    6'd22, 6'd24, 6'd21, 6'd23, 6'd20, 6'd22,
    6'd0, 6'd4, 6'd2, 6'd6, 6'd1, 6'd5
  };

  function automatic string req_of(int i);
    if (i == 0) return "R3";
    if (i == 1) return "R4";
    if (i < 8)  return "R5";
    return "R6";
  endfunction

  task automatic chk(bit ok, string req, int act, int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual %0d expected %0d", req, act, exp);
    end
  endtask

  task automatic collect(int first, int n, output int span);
    int got = 0, f = -1, l = -1;
    repeat (40) begin
      @(negedge clk);
      if (addr_vld) begin
        if (got < n) chk(addr == EXP[first+got], req_of(first+got), addr, EXP[first+got]);
        if (f < 0) f = cyc;
        l = cyc;
        got++;
      end
    end
    chk(got == n, "R8", got, n);
    span = l - f;
  endtask

  task automatic kick(int pc0);
    start = 1'b1;
    start_pc = 6'(pc0);
    @(negedge clk);
    start = 1'b0;
  endtask

  initial begin
    #(8 * 20000);
    errors++;
    $display("FAIL watchdog actual 0 expected 1");
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    int span, quiet;
    rst_n = 1'b0; ld_we = 1'b0; start = 1'b0; addr_req = 1'b0;
    ld_addr = '0; start_pc = '0; ld_data = '0;
    repeat (3) @(negedge clk);
    chk(addr_vld == 1'b0, "R1", addr_vld, 0);
    rst_n = 1'b1;
    repeat (3) @(negedge clk);
    chk(addr_vld == 1'b0, "R1", addr_vld, 0);

    // R2: load program through the load port
    for (int i = 0; i < 14; i++) begin
      ld_we = 1'b1; ld_addr = 6'(i); ld_data = PROG[i];
      @(negedge clk);
    end
    ld_we = 1'b0;

    // R7: no request -> sequencer holds, nothing emitted
    kick(0);
    quiet = 0;
    repeat (8) begin
      @(negedge clk);
      if (addr_vld) quiet++;
    end
    chk(quiet == 0, "R7", quiet, 0);
    addr_req = 1'b1;
    collect(0, 2, span);                 // R3 and R4
    chk(span == 1, "R7", span, 1);

    // R8: after halt, requests are ignored
    quiet = 0;
    repeat (6) begin
      @(negedge clk);
      if (addr_vld) quiet++;
    end
    chk(quiet == 0, "R8", quiet, 0);

    // R5, R9, R11: modulo window inside a single-level loop, no bubbles
    kick(4);
    collect(2, 6, span);
    chk(span == 5, "R9", span, 5);

    // R6, R10: nested loops (levels 0 and 3) ending on the same word
    kick(9);
    collect(8, 6, span);
    chk(span == 6, "R10", span, 6);

    // R2: wake again from idle, program restarts from its entry word
    kick(0);
    collect(0, 2, span);

    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule